// File: doc/BRIEF.md
# Gated 32-bit Period Timer

This block is a 32-bit up-counter made of two 16-bit halves joined by a carry. Its counting tick comes from one of two sources: the core clock rate or the rising edges of an external clock pin. A prescaler divides that tick by 1, 8, 64 or 256. The counter is compared with a 32-bit period value. On a match, the next counting tick returns the count to zero, a one-cycle converter trigger pulse goes out, and a sticky interrupt flag is set.

In gated accumulation mode the block measures how long an external gate input stays high. While the gate is high, the counter advances on prescaled internal ticks. When the gate falls, counting stops and the count is kept. The falling edge also sets the interrupt flag, so software can read the accumulated width. Software writes control, both count halves and both period halves through a single write port. A separate strobe clears the flag.

Top module: `gated_period_timer`

## Requirements
- R1: After reset the count, the period, the control fields, the interrupt flag, the request output and the trigger output are all zero.
- R2: A write with `wrAddr` 0 loads control, 1 loads count bits 15:0, 2 loads count bits 31:16, 3 loads period bits 15:0 and 4 loads period bits 31:16. A count-half write replaces only that half, is visible on the next cycle, and wins over a counting tick in the same cycle.
- R3: The control word layout is: bit 0 run, bit 1 external clock select, bit 2 gate enable, bits 4:3 prescale code, bit 5 interrupt enable.
- R4: The prescale codes 00, 01, 10 and 11 divide the source tick by 1, 8, 64 and 256. With a cleared prescaler, the first increment happens on the Nth source tick after run is set.
- R5: The prescaler clears on a count-half write while running and on a run 1-to-0 control write. While stopped it does not advance.
- R6: When a counting tick finds the count equal to the period, the count becomes zero, `adcTrig` is high for the following cycle and the flag is set. A period of zero holds the count at zero and triggers on every tick.
- R7: A carry out of the low half increments the high half on the same tick.
- R8: With the external clock selected, each rising edge of `extClkIn` is a source tick after a two-flop synchronizer. The count changes on the third clock edge after the input rises.
- R9: Gated mode is active only when gate enable and run are set and the internal source is selected. It counts prescaled ticks only while the synchronized gate is high.
- R10: In gated mode a synchronized falling gate edge stops counting, keeps the count and sets the flag. Outside gated mode the gate input has no effect on the count or the flag.
- R11: The flag stays set until a `flagClr` strobe, and a set event in the same cycle wins. `irqReq` is high exactly when the flag and the interrupt enable are both set.
- R12: A control write does not change the count.
- R13: While run is clear the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the internal tick |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 16 | Register write data |
| gateIn | input | 1 | Asynchronous gate level |
| extClkIn | input | 1 | Asynchronous external clock |
| flagClr | input | 1 | Interrupt flag clear strobe |
| timerValue | output | 32 | Current count |
| adcTrig | output | 1 | One-cycle period-match pulse |
| irqFlag | output | 1 | Sticky interrupt flag |
| irqReq | output | 1 | Flag qualified by interrupt enable |

## Verification
A prescaler that is off by one shows up at the count output one divided tick early or late. The bench therefore samples the count on the exact cycle before and after each expected increment. If the clear rule for the prescaler is wrong, the phase of the next increment after a count write or a stop shifts, and the error shows within one division period. A wrong synchronizer depth or wrong edge detector moves the external-clock increment or the gate-fall flag by a cycle. A broken gate qualifier changes the accumulated width, so the gate tests check both the final count and the exact cycle the flag rises.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PSC_W  = 8;   // holds the largest divisor minus one (255)
  localparam int unsigned CTRL_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_CNT_HI = 3'd2,
    REG_PER_LO = 3'd3,
    REG_PER_HI = 3'd4
  } regSel_e;

  // Packed MSB first: irqEn is bit 5, run is bit 0.
  typedef struct packed {
    logic       irqEn;
    logic [1:0] psc;
    logic       gateEn;
    logic       extSel;
    logic       run;
  } ctrlFields_t;

  typedef struct packed {
    logic countTick;
    logic loadCntLo;
    logic loadCntHi;
    logic loadPerLo;
    logic loadPerHi;
  } dpStrobe_t;

  function automatic logic [PSC_W-1:0] pscLast(input logic [1:0] code);
    case (code)
      2'b00:   pscLast = PSC_W'(0);
      2'b01:   pscLast = PSC_W'(7);
      2'b10:   pscLast = PSC_W'(63);
      default: pscLast = PSC_W'(255);
    endcase
  endfunction

endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic level,
  output logic levelPrev
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) levelPrev <= 1'b0;
    else       levelPrev <= chain[STAGES-1];

  assign level = chain[STAGES-1];
endmodule

// File: rtl/gpt_ctrl.sv
module gpt_ctrl
  import gpt_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [CTRL_W-1:0]        ctrlData,
  input  logic                     gateLvl,
  input  logic                     gatePrev,
  input  logic                     extLvl,
  input  logic                     extPrev,
  input  logic                     matchTick,
  input  logic                     flagClr,
  output dpStrobe_t                strobe,
  output ctrlFields_t              ctrlQ,
  output logic                     irqFlag,
  output logic                     irqReq
);
  logic              wrCtrl, wrCntLo, wrCntHi, cntWrite;
  ctrlFields_t       ctrlNew;
  logic              runFall, pscClr, srcTick, pscTick, gatedMode;
  logic              gateFall, extRise, flagSet;
  logic [PSC_W-1:0]  pscCnt;

  assign wrCtrl   = wrEn && (wrAddr == REG_CTRL);
  assign wrCntLo  = wrEn && (wrAddr == REG_CNT_LO);
  assign wrCntHi  = wrEn && (wrAddr == REG_CNT_HI);
  assign cntWrite = wrCntLo || wrCntHi;
  assign ctrlNew  = ctrlFields_t'(ctrlData);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)       ctrlQ <= '0;
    else if (wrCtrl) ctrlQ <= ctrlNew;

  assign gateFall = gatePrev && !gateLvl;
  assign extRise  = extLvl && !extPrev;

  // Prescaler: frozen while stopped, cleared by a stop or by a count write while running.
  assign runFall = wrCtrl && ctrlQ.run && !ctrlNew.run;
  assign pscClr  = runFall || (ctrlQ.run && cntWrite);
  assign srcTick = ctrlQ.extSel ? extRise : 1'b1;
  assign pscTick = ctrlQ.run && srcTick && (pscCnt >= pscLast(ctrlQ.psc));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                       pscCnt <= '0;
    else if (pscClr)                 pscCnt <= '0;
    else if (ctrlQ.run && srcTick)   pscCnt <= pscTick ? '0 : pscCnt + PSC_W'(1);

  assign gatedMode = ctrlQ.gateEn && ctrlQ.run && !ctrlQ.extSel;

  always_comb begin
    strobe.countTick = pscTick && (!gatedMode || gateLvl);
    strobe.loadCntLo = wrCntLo;
    strobe.loadCntHi = wrCntHi;
    strobe.loadPerLo = wrEn && (wrAddr == REG_PER_LO);
    strobe.loadPerHi = wrEn && (wrAddr == REG_PER_HI);
  end

  assign flagSet = matchTick || (gatedMode && gateFall);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)        irqFlag <= 1'b0;
    else if (flagSet) irqFlag <= 1'b1;
    else if (flagClr) irqFlag <= 1'b0;

  assign irqReq = irqFlag && ctrlQ.irqEn;
endmodule

// File: rtl/gpt_datapath.sv
module gpt_datapath
  import gpt_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [HALF_W-1:0]     wrData,
  output logic [2*HALF_W-1:0]   count,
  output logic                  matchTick,
  output logic                  adcTrig
);
  localparam int unsigned FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] cntHalf [2];
  logic [HALF_W-1:0] perHalf [2];
  logic [FULL_W-1:0] period, countNext;
  logic [1:0]        cntLoad, perLoad;
  logic              anyLoad, atPeriod, advance;

  assign cntLoad = {strobe.loadCntHi, strobe.loadCntLo};
  assign perLoad = {strobe.loadPerHi, strobe.loadPerLo};
  assign anyLoad = |cntLoad;

  assign count     = {cntHalf[1], cntHalf[0]};
  assign period    = {perHalf[1], perHalf[0]};
  assign atPeriod  = (count == period);
  assign advance   = strobe.countTick && !anyLoad;
  assign matchTick = advance && atPeriod;
  assign countNext = atPeriod ? '0 : count + FULL_W'(1);

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      always_ff @(posedge clk or negedge rstN)
        if (!rstN)           cntHalf[h] <= '0;
        else if (cntLoad[h]) cntHalf[h] <= wrData;
        else if (advance)    cntHalf[h] <= countNext[h*HALF_W +: HALF_W];

      always_ff @(posedge clk or negedge rstN)
        if (!rstN)           perHalf[h] <= '0;
        else if (perLoad[h]) perHalf[h] <= wrData;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) adcTrig <= 1'b0;
    else       adcTrig <= matchTick;
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
  import gpt_pkg::*;
#(
  parameter int unsigned HALF_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [HALF_W-1:0]     wrData,
  input  logic                  gateIn,
  input  logic                  extClkIn,
  input  logic                  flagClr,
  output logic [2*HALF_W-1:0]   timerValue,
  output logic                  adcTrig,
  output logic                  irqFlag,
  output logic                  irqReq
);
  logic        gateLvl, gatePrev, extLvl, extPrev, matchTick, runNow;
  dpStrobe_t   strobe;
  ctrlFields_t ctrlQ;

  gpt_sync #(.STAGES(SYNC_STAGES)) gateSync_i (
    .clk(clk), .rstN(rstN), .din(gateIn), .level(gateLvl), .levelPrev(gatePrev));

  gpt_sync #(.STAGES(SYNC_STAGES)) extSync_i (
    .clk(clk), .rstN(rstN), .din(extClkIn), .level(extLvl), .levelPrev(extPrev));

  gpt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .ctrlData(wrData[CTRL_W-1:0]),
    .gateLvl(gateLvl), .gatePrev(gatePrev), .extLvl(extLvl), .extPrev(extPrev),
    .matchTick(matchTick), .flagClr(flagClr),
    .strobe(strobe), .ctrlQ(ctrlQ), .irqFlag(irqFlag), .irqReq(irqReq));

  gpt_datapath #(.HALF_W(HALF_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .count(timerValue), .matchTick(matchTick), .adcTrig(adcTrig));

  assign runNow = ctrlQ.run;
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
  parameter int unsigned HALF_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [2:0]          wrAddr,
  input logic [HALF_W-1:0]   wrData,
  input logic                flagClr,
  input logic [2*HALF_W-1:0] timerValue,
  input logic                adcTrig,
  input logic                irqFlag,
  input logic                run
);
  // R2
  lo_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd1) |=> (timerValue[HALF_W-1:0] == $past(wrData)));

  // R2
  hi_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd2) |=> (timerValue[2*HALF_W-1:HALF_W] == $past(wrData)));

  // R6
  trig_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcTrig |-> irqFlag);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag);

  // R13
  stopped_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !wrEn) |=> $stable(timerValue));

  // R12
  ctrl_write_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run && wrEn && wrAddr == 3'd0) |=> $stable(timerValue));
endmodule

bind gated_period_timer gpt_checker #(.HALF_W(HALF_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .flagClr(flagClr), .timerValue(timerValue), .adcTrig(adcTrig),
  .irqFlag(irqFlag), .run(runNow));

// File: tb/gated_period_timer_tb_top.sv
`timescale 1ns/1ps
module gated_period_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        gateIn = 1'b0;
  logic        extClkIn = 1'b0;
  logic        flagClr = 1'b0;
  logic [31:0] timerValue;
  logic        adcTrig, irqFlag, irqReq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gated_period_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gateIn(gateIn), .extClkIn(extClkIn), .flagClr(flagClr),
    .timerValue(timerValue), .adcTrig(adcTrig), .irqFlag(irqFlag), .irqReq(irqReq));

  localparam logic [2:0] A_CTRL = 3'd0, A_CLO = 3'd1, A_CHI = 3'd2, A_PLO = 3'd3, A_PHI = 3'd4;

  function automatic logic [15:0] mkCtrl(input logic run, input logic ext, input logic gate,
                                         input logic [1:0] psc, input logic irq);
    mkCtrl = {10'd0, irq, psc, gate, ext, run};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step(1);
    wrEn = 1'b0;
  endtask

  task automatic clearFlag();
    flagClr = 1'b1;
    step(1);
    flagClr = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tReset();
    check("R1 count", timerValue, 32'd0);
    check("R1 flag", {31'd0, irqFlag}, 32'd0);
    check("R1 trig", {31'd0, adcTrig}, 32'd0);
    check("R1 req", {31'd0, irqReq}, 32'd0);
  endtask

  task automatic tFreeRun();
    wr(A_PLO, 16'd5);
    wr(A_PHI, 16'd0);
    wr(A_CTRL, mkCtrl(1, 0, 0, 2'b00, 0));   // R3 run bit
    step(5);
    check("R6 count reaches period", timerValue, 32'd5);
    check("R6 no trig before match", {31'd0, adcTrig}, 32'd0);
    step(1);
    check("R6 wrap to zero", timerValue, 32'd0);
    check("R6 trig pulse", {31'd0, adcTrig}, 32'd1);
    check("R6 flag set", {31'd0, irqFlag}, 32'd1);
    step(1);
    check("R6 trig one cycle", {31'd0, adcTrig}, 32'd0);
    check("R11 flag sticky", {31'd0, irqFlag}, 32'd1);
    check("R11 req masked", {31'd0, irqReq}, 32'd0);
    wr(A_CTRL, mkCtrl(1, 0, 0, 2'b00, 1));   // R3 irq enable bit
    check("R11 req enabled", {31'd0, irqReq}, 32'd1);
    check("R12 count keeps running through ctrl write", timerValue, 32'd2);
    clearFlag();
    check("R11 flag cleared", {31'd0, irqFlag}, 32'd0);
    check("R11 req drops", {31'd0, irqReq}, 32'd0);
    wr(A_CTRL, 16'd0);
    step(3);
    check("R13 held while stopped", timerValue, 32'd4);
    wr(A_CTRL, mkCtrl(0, 1, 1, 2'b11, 1));
    check("R12 ctrl write keeps count", timerValue, 32'd4);
  endtask

  task automatic tPrescale();
    wr(A_CLO, 16'd0);
    wr(A_CHI, 16'd0);
    wr(A_PLO, 16'hFFFF);
    wr(A_PHI, 16'hFFFF);
    for (int code = 1; code < 4; code++) begin
      int div;
      div = (code == 1) ? 8 : (code == 2) ? 64 : 256;
      wr(A_CLO, 16'd0);
      wr(A_CTRL, mkCtrl(1, 0, 0, code[1:0], 0));
      step(div - 1);
      check("R4 no step before divisor", timerValue, 32'd0);
      step(1);
      check("R4 first step at divisor", timerValue, 32'd1);
      step(div);
      check("R4 second step", timerValue, 32'd2);
      wr(A_CTRL, 16'd0);
    end
  endtask

  task automatic tPscClear();
    wr(A_CLO, 16'd0);
    wr(A_CTRL, mkCtrl(1, 0, 0, 2'b01, 0));
    step(5);
    wr(A_CLO, 16'd100);
    check("R2 write beats tick", timerValue, 32'd100);
    step(7);
    check("R5 count write clears prescaler", timerValue, 32'd100);
    step(1);
    check("R5 step after full division", timerValue, 32'd101);
    step(3);
    wr(A_CTRL, mkCtrl(0, 0, 0, 2'b01, 0));
    wr(A_CTRL, mkCtrl(1, 0, 0, 2'b01, 0));
    step(7);
    check("R5 stop clears prescaler", timerValue, 32'd101);
    step(1);
    check("R5 step after restart", timerValue, 32'd102);
    wr(A_CTRL, 16'd0);
  endtask

  task automatic tCarry();
    wr(A_CHI, 16'd0);
    wr(A_CLO, 16'hFFFF);
    check("R2 low half only", timerValue, 32'h0000_FFFF);
    wr(A_PLO, 16'd1);
    wr(A_PHI, 16'd1);
    clearFlag();
    wr(A_CTRL, mkCtrl(1, 0, 0, 2'b00, 0));
    step(1);
    check("R7 carry into high half", timerValue, 32'h0001_0000);
    step(1);
    step(1);
    check("R6 match across halves", timerValue, 32'd0);
    check("R6 trig on wide match", {31'd0, adcTrig}, 32'd1);
    wr(A_CTRL, 16'd0);
  endtask

  task automatic tZeroPeriod();
    wr(A_CLO, 16'd0);
    wr(A_CHI, 16'd0);
    wr(A_PLO, 16'd0);
    wr(A_PHI, 16'd0);
    clearFlag();
    wr(A_CTRL, mkCtrl(1, 0, 0, 2'b00, 0));
    step(1);
    check("R6 zero period trig", {31'd0, adcTrig}, 32'd1);
    step(1);
    check("R6 zero period holds zero", timerValue, 32'd0);
    check("R6 zero period trig again", {31'd0, adcTrig}, 32'd1);
    wr(A_CTRL, 16'd0);
    step(1);
  endtask

  task automatic tExtClock();
    wr(A_CLO, 16'd0);
    wr(A_PLO, 16'hFFFF);
    wr(A_PHI, 16'hFFFF);
    clearFlag();
    wr(A_CTRL, mkCtrl(1, 1, 1, 2'b00, 0));   // gate enable set but external source
    extClkIn = 1'b1; gateIn = 1'b1;
    step(2);
    check("R8 not yet through synchronizer", timerValue, 32'd0);
    step(1);
    check("R8 count on third edge", timerValue, 32'd1);
    step(2);
    extClkIn = 1'b0; gateIn = 1'b0;
    step(4);
    for (int p = 0; p < 2; p++) begin
      extClkIn = 1'b1; gateIn = 1'b1;
      step(4);
      extClkIn = 1'b0; gateIn = 1'b0;
      step(4);
    end
    check("R8 one step per rising edge", timerValue, 32'd3);
    check("R10 gate ignored outside gated mode", {31'd0, irqFlag}, 32'd0);
    wr(A_CTRL, 16'd0);
  endtask

  task automatic tGated();
    wr(A_CLO, 16'd0);
    wr(A_CHI, 16'd0);
    clearFlag();
    wr(A_CTRL, mkCtrl(1, 0, 1, 2'b00, 1));
    step(3);
    check("R9 no count while gate low", timerValue, 32'd0);
    gateIn = 1'b1;
    step(10);
    gateIn = 1'b0;
    step(2);
    check("R9 count equals high width", timerValue, 32'd10);
    check("R10 flag not yet", {31'd0, irqFlag}, 32'd0);
    step(1);
    check("R10 fall sets flag", {31'd0, irqFlag}, 32'd1);
    check("R11 request with enable", {31'd0, irqReq}, 32'd1);
    step(5);
    check("R10 count kept after fall", timerValue, 32'd10);
    wr(A_CTRL, 16'd0);
  endtask

  initial begin
    step(3);
    tReset();
    rstN = 1'b1;
    step(1);
    tFreeRun();
    tPrescale();
    tPscClear();
    tCarry();
    tZeroPeriod();
    tExtClock();
    tGated();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule